// File: doc/BRIEF.md
# Byte Parity Write/Read Path

This block sits between a memory controller and the data pins of a DRAM. On the write side it adds one parity bit to every data byte. The result is a 9-bit storage lane per byte, and the path is purely combinational. On the read side it takes the 9-bit lanes back from storage and checks each one. It drops the parity bits and returns the bare data bytes one clock later. Alongside the data it returns a per-byte error vector and a summary error bit.

Two static configuration inputs shape the behaviour. The first selects odd or even parity. The second selects a fake-parity mode. In fake-parity mode the stored parity bit is discarded and a parity bit is rebuilt from the read data itself, so the check always passes and corrupt data goes unflagged. The configuration is taken into an internal mode register only on cycles when no read is being presented. A change made while reads stream in therefore takes effect only after the stream ends.

Top module: `byte_parity_path`

## Requirements
- R1: Lane i of `wr_lanes` and `rd_lanes` occupies bits [9i+8:9i]. Bit 9i+8 is the parity bit and bits [9i+7:9i] carry data byte i (bits [8i+7:8i] of the data word). The write path copies the data bits unchanged.
- R2: In odd mode (mode odd bit 1), the written parity bit is 1 when its byte has an even number of ones and 0 when the count is odd.
- R3: In even mode (mode odd bit 0), the written parity bit is 0 when its byte has an even number of ones and 1 when the count is odd.
- R4: On a read with fake mode off, `rd_err[i]` is 1 exactly when lane i has an even total of ones in odd mode, or an odd total of ones in even mode.
- R5: `rd_data` byte i equals the 8 data bits of lane i, with the parity bit removed, whether or not that lane is in error.
- R6: In fake-parity mode, `rd_err` and `rd_err_any` stay 0 for every read and for any lane content, while the data is still returned stripped.
- R7: Two flipped bits inside one lane leave its error flag clear. A single flipped bit sets the flag of that byte only.
- R8: `rd_err_any` is 1 exactly when at least one bit of `rd_err` is 1 in the same cycle.
- R9: `rd_valid_out` follows `rd_valid_in` one clock later, and data and flags appear in that same cycle. While `rd_valid_out` is 0, `rd_err` and `rd_err_any` are 0.
- R10: The mode register loads `cfg_odd` and `cfg_fake` at a clock edge only when `rd_valid_in` was 0 in the preceding cycle. After reset it holds even parity with fake mode off. Both the write path and the read path use the registered mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_fake | input | 1 | 1 selects fake-parity mode |
| wr_data | input | NUM_BYTES*8 | Write data word |
| wr_lanes | output | NUM_BYTES*9 | Write lanes (data plus parity) for storage |
| rd_valid_in | input | 1 | A read lane word is present this cycle |
| rd_lanes | input | NUM_BYTES*9 | Lanes read back from storage |
| rd_valid_out | output | 1 | Read result valid |
| rd_data | output | NUM_BYTES*8 | Stripped read data |
| rd_err | output | NUM_BYTES | Per-byte parity error flags |
| rd_err_any | output | 1 | OR of all error flags |

## Verification
The bench sweeps all 256 values of byte 0 in both parity senses. Each write lane is compared against a ones count done in the bench, so a swapped odd/even rule, or a parity bit placed in the wrong lane position, shows up at once. On reads it applies single-bit and paired-bit corruption at every position in a lane, including the parity bit itself. A checker that is sensitive to pairs of flips, that flags the wrong byte, or that lets a corrupted parity bit through would be caught. It runs fake mode over corrupt lanes to show that no flag rises, and it changes the configuration while reads are streaming to show that the old mode holds until the stream stops. Each read is also compared one cycle late, so output registered at the wrong depth fails.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANE_W = BYTE_W + 1;

    typedef struct packed {
        logic odd;
        logic fake;
    } bpar_mode_t;

    typedef struct packed {
        logic              par;
        logic [BYTE_W-1:0] data;
    } bpar_lane_t;

    localparam bpar_mode_t MODE_RESET = '{odd: 1'b0, fake: 1'b0};

    // parity bit that makes the lane meet the selected rule
    function automatic logic make_par(input logic [BYTE_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // 1 when the lane breaks the selected rule
    function automatic logic lane_bad(input bpar_lane_t l, input logic odd);
        return (^{l.par, l.data}) ^ odd;
    endfunction

endpackage

// File: rtl/bpar_mode_ctl.sv
module bpar_mode_ctl
    import bpar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_odd,
    input  logic       cfg_fake,
    input  logic       busy,
    output bpar_mode_t mode
);

    bpar_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
        end else if (!busy) begin
            mode_q <= '{odd: cfg_odd, fake: cfg_fake};
        end
    end

    assign mode = mode_q;

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q));

    p_mode_load_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (mode_q == {$past(cfg_odd), $past(cfg_fake)}));

endmodule

// File: rtl/bpar_lane_gen.sv
module bpar_lane_gen
    import bpar_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4
) (
    input  logic                        odd,
    input  logic [NUM_BYTES*BYTE_W-1:0] data,
    output logic [NUM_BYTES*LANE_W-1:0] lanes
);

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        bpar_lane_t lane;
        always_comb begin
            lane.data = data[g*BYTE_W +: BYTE_W];
            lane.par  = make_par(lane.data, odd);
        end
        assign lanes[g*LANE_W +: LANE_W] = lane;

        always_comb begin
            a_lane_ok_r2: assert (lane_bad(lane, odd) == 1'b0);
        end
    end

endmodule

// File: rtl/bpar_lane_chk.sv
module bpar_lane_chk
    import bpar_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4
) (
    input  bpar_mode_t                  mode,
    input  logic [NUM_BYTES*LANE_W-1:0] lanes,
    output logic [NUM_BYTES*BYTE_W-1:0] data,
    output logic [NUM_BYTES-1:0]        err
);

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_chk
        bpar_lane_t stored;
        bpar_lane_t seen;
        assign stored = lanes[g*LANE_W +: LANE_W];

        always_comb begin
            seen.data = stored.data;
            // fake mode rebuilds the bit from the data leaving the block
            seen.par  = mode.fake ? make_par(stored.data, mode.odd) : stored.par;
        end

        assign data[g*BYTE_W +: BYTE_W] = stored.data;
        assign err[g] = lane_bad(seen, mode.odd);
    end

endmodule

// File: rtl/bpar_rd_stage.sv
module bpar_rd_stage
    import bpar_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        vld_in,
    input  logic [NUM_BYTES*BYTE_W-1:0] data_in,
    input  logic [NUM_BYTES-1:0]        err_in,
    output logic                        vld_out,
    output logic [NUM_BYTES*BYTE_W-1:0] data_out,
    output logic [NUM_BYTES-1:0]        err_out,
    output logic                        any_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_out  <= 1'b0;
            data_out <= '0;
            err_out  <= '0;
            any_out  <= 1'b0;
        end else begin
            vld_out <= vld_in;
            if (vld_in) begin
                data_out <= data_in;
                err_out  <= err_in;
                any_out  <= |err_in;
            end else begin
                err_out  <= '0;
                any_out  <= 1'b0;
            end
        end
    end

    p_lat_on_r9: assert property (@(posedge clk) disable iff (rst)
        vld_in |=> vld_out);

    p_lat_off_r9: assert property (@(posedge clk) disable iff (rst)
        !vld_in |=> !vld_out);

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !vld_out |-> (err_out == '0 && !any_out));

    p_any_or_r8: assert property (@(posedge clk) disable iff (rst)
        any_out == (err_out != '0));

endmodule

// File: rtl/byte_parity_path.sv
module byte_parity_path
    import bpar_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4,
    localparam int unsigned DW = NUM_BYTES * BYTE_W,
    localparam int unsigned LW = NUM_BYTES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_odd,
    input  logic                 cfg_fake,
    input  logic [DW-1:0]        wr_data,
    output logic [LW-1:0]        wr_lanes,
    input  logic                 rd_valid_in,
    input  logic [LW-1:0]        rd_lanes,
    output logic                 rd_valid_out,
    output logic [DW-1:0]        rd_data,
    output logic [NUM_BYTES-1:0] rd_err,
    output logic                 rd_err_any
);

    bpar_mode_t           mode;
    logic [DW-1:0]        chk_data;
    logic [NUM_BYTES-1:0] chk_err;

    bpar_mode_ctl i_mode (
        .clk      (clk),
        .rst      (rst),
        .cfg_odd  (cfg_odd),
        .cfg_fake (cfg_fake),
        .busy     (rd_valid_in),
        .mode     (mode)
    );

    bpar_lane_gen #(.NUM_BYTES(NUM_BYTES)) i_gen (
        .odd   (mode.odd),
        .data  (wr_data),
        .lanes (wr_lanes)
    );

    bpar_lane_chk #(.NUM_BYTES(NUM_BYTES)) i_chk (
        .mode  (mode),
        .lanes (rd_lanes),
        .data  (chk_data),
        .err   (chk_err)
    );

    bpar_rd_stage #(.NUM_BYTES(NUM_BYTES)) i_stage (
        .clk      (clk),
        .rst      (rst),
        .vld_in   (rd_valid_in),
        .data_in  (chk_data),
        .err_in   (chk_err),
        .vld_out  (rd_valid_out),
        .data_out (rd_data),
        .err_out  (rd_err),
        .any_out  (rd_err_any)
    );

    // mode cannot move between capture and output, so fake mode at output time holds
    p_fake_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (mode.fake && rd_valid_out) |-> (rd_err == '0 && !rd_err_any));

    p_strip_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid_in |=> (rd_data == $past(chk_data)));

endmodule

// File: tb/test_byte_parity_path.sv
module test_byte_parity_path;
    localparam int NB = 4;
    localparam int DW = NB * 8;
    localparam int LW = NB * 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_odd = 1'b0;
    logic          cfg_fake = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [LW-1:0] wr_lanes;
    logic          rd_valid_in = 1'b0;
    logic [LW-1:0] rd_lanes = '0;
    logic          rd_valid_out;
    logic [DW-1:0] rd_data;
    logic [NB-1:0] rd_err;
    logic          rd_err_any;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    byte_parity_path #(.NUM_BYTES(NB)) i_byte_parity_path (
        .clk(clk), .rst(rst), .cfg_odd(cfg_odd), .cfg_fake(cfg_fake),
        .wr_data(wr_data), .wr_lanes(wr_lanes),
        .rd_valid_in(rd_valid_in), .rd_lanes(rd_lanes),
        .rd_valid_out(rd_valid_out), .rd_data(rd_data),
        .rd_err(rd_err), .rd_err_any(rd_err_any)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] model_lanes(input logic [DW-1:0] d, input logic odd);
        logic [LW-1:0] l;
        for (int b = 0; b < NB; b++) begin
            logic [7:0] by;
            by = d[b*8 +: 8];
            l[b*9 +: 8] = by;
            l[b*9 + 8]  = (($countones(by) % 2) == 0) ? odd : ~odd;
        end
        return l;
    endfunction

    function automatic logic [NB-1:0] model_err(input logic [LW-1:0] l, input logic odd);
        logic [NB-1:0] e;
        for (int b = 0; b < NB; b++) begin
            logic even_cnt;
            even_cnt = ($countones(l[b*9 +: 9]) % 2) == 0;
            e[b] = odd ? even_cnt : ~even_cnt;
        end
        return e;
    endfunction

    function automatic logic [DW-1:0] model_strip(input logic [LW-1:0] l);
        logic [DW-1:0] d;
        for (int b = 0; b < NB; b++) d[b*8 +: 8] = l[b*9 +: 8];
        return d;
    endfunction

    // set mode: one idle edge loads it
    task automatic set_mode(input logic odd, input logic fake);
        @(negedge clk);
        rd_valid_in = 1'b0;
        cfg_odd = odd;
        cfg_fake = fake;
        @(negedge clk);
    endtask

    // present one read; returns after the result is visible
    task automatic do_read(input logic [LW-1:0] l);
        @(negedge clk);
        rd_valid_in = 1'b1;
        rd_lanes = l;
        @(negedge clk);
    endtask

    task automatic check_read(input string req, input logic [LW-1:0] l, input logic odd, input logic fake);
        logic [NB-1:0] e;
        e = fake ? '0 : model_err(l, odd);
        check({req, " valid"}, 64'(rd_valid_out), 64'd1);
        check({req, " data"}, 64'(rd_data), 64'(model_strip(l)));
        check({req, " err"}, 64'(rd_err), 64'(e));
        check({req, " any"}, 64'(rd_err_any), 64'(|e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: idle outputs, even mode (R10, R9)
        check("R9 reset valid", 64'(rd_valid_out), 64'd0);
        check("R9 reset err", 64'(rd_err), 64'd0);
        check("R8 reset any", 64'(rd_err_any), 64'd0);
        wr_data = 32'h0000_0001;
        #1;
        check("R10 reset even mode", 64'(wr_lanes), 64'(model_lanes(32'h1, 1'b0)));

        for (int m = 0; m < 2; m++) begin
            logic odd;
            odd = m[0];
            set_mode(odd, 1'b0);
            for (int v = 0; v < 256; v++) begin
                logic [7:0] b0;
                logic [DW-1:0] d;
                logic [LW-1:0] good;
                logic [LW-1:0] one;
                logic [LW-1:0] two;
                int bsel;
                int k;
                b0 = v[7:0];
                d = {b0 ^ 8'h5A, b0 + 8'd1, ~b0, b0};
                @(negedge clk);
                rd_valid_in = 1'b0;
                wr_data = d;
                #1;
                check(odd ? "R2 R1 write lanes odd" : "R3 R1 write lanes even",
                      64'(wr_lanes), 64'(model_lanes(d, odd)));
                good = wr_lanes;
                bsel = v % NB;
                k = v % 9;
                one = good;
                one[bsel*9 + k] = ~one[bsel*9 + k];
                two = one;
                two[bsel*9 + (k + 1) % 9] = ~two[bsel*9 + (k + 1) % 9];

                do_read(good);
                check_read("R4 R5 clean", good, odd, 1'b0);
                check("R4 clean no err", 64'(rd_err), 64'd0);
                do_read(one);
                check_read("R4 R5 single", one, odd, 1'b0);
                check("R7 single flags one byte", 64'(rd_err), 64'(NB'(1) << bsel));
                do_read(two);
                check_read("R7 double", two, odd, 1'b0);
                check("R7 double hidden", 64'(rd_err_any), 64'd0);
                @(negedge clk);
                rd_valid_in = 1'b0;
                @(negedge clk);
                check("R9 idle err clear", 64'({rd_valid_out, rd_err, rd_err_any}), 64'd0);
            end
        end

        // fake mode: corrupt lanes go unflagged (R6)
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0], 1'b1);
            for (int v = 0; v < 64; v++) begin
                logic [LW-1:0] l;
                l = LW'({v[5:0], 30'h2A5C_3E19}) ^ LW'(36'h1_0000_0001 << v[4:0]);
                do_read(l);
                check_read("R6 fake", l, m[0], 1'b1);
            end
        end

        // mode held while reads stream (R10)
        set_mode(1'b1, 1'b0);
        do_read(36'h0);
        cfg_odd = 1'b0;
        do_read(36'h0);
        check("R10 held odd", 64'(rd_err), 64'hF);
        cfg_fake = 1'b1;
        do_read(36'h0);
        check("R10 held no fake", 64'(rd_err_any), 64'd1);
        @(negedge clk);
        rd_valid_in = 1'b0;
        @(negedge clk);
        do_read(36'h0);
        check("R10 loaded after idle", 64'(rd_err_any), 64'd0);
        set_mode(1'b0, 1'b0);
        do_read(36'h1_0000_0000);
        check("R8 any from top byte", 64'({rd_err, rd_err_any}), 64'b1000_1);
        @(negedge clk);
        rd_valid_in = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule